// File: doc/BRIEF.md
# Video CRTC Memory Address Mapper

This block converts the display controller's linear character address into the physical address used to fetch refresh data from video memory. Each request adds a frame start address to a running character offset. For a display fetch, the block then rearranges the address bits according to the access width:

- **Byte mode:** the address passes through unchanged.
- **Word mode:** the address is rotated left by one.
- **Doubleword mode:** the address is rotated left by two.

After this rotation, the two low bits of the row scan counter can take the place of address bits 13 and 14. This splits memory into two or four banks of interleaved scanlines.

Processor accesses skip the rearrangement and use the linear sum unchanged. Every request also yields a byte offset into the 256 KiB plane-interleaved memory. That offset is the mapped address times four, plus the plane index.

Requests arrive with a valid strobe. Results appear, registered, one clock later with their own strobe, and they hold until the next request.

Top module: `crtc_addr_map`

## Requirements
- R1: `outValid` is high in the cycle after a clock edge that sampled `inValid` high, and low after an edge that sampled it low.
- R2: While `inValid` is low, `mappedAddr` and `byteOffset` keep their values, whatever the other inputs do.
- R3: While `rstN` is low, `outValid`, `mappedAddr` and `byteOffset` are all zero.
- R4: With `isRender` low, `mappedAddr` equals the linear address, whatever the mode and substitution inputs are.
- R5: With `isRender` high, `byteMode` high, `dwordMode` low and both keep bits high, `mappedAddr` equals the linear address.
- R6: In word mode (`isRender` high, `dwordMode` low, `byteMode` low) with `wrapSel` low, `mappedAddr` is the linear address shifted left by one, truncated to 16 bits, with linear bit 13 in bit 0.
- R7: In word mode with `wrapSel` high, bit 0 of `mappedAddr` takes linear bit 15 instead of bit 13.
- R8: With `isRender` and `dwordMode` high, `mappedAddr` is the linear address shifted left by two, truncated to 16 bits, with linear bits 13:12 in bits 1:0. `byteMode` and `wrapSel` have no effect in this mode.
- R9: With `isRender` high and `keepBit13` low, bit 13 of `mappedAddr` equals `rowScan[0]`. This substitution is applied after the rotation.
- R10: With `isRender` high and `keepBit14` low, bit 14 of `mappedAddr` equals `rowScan[1]`. This substitution is applied after the rotation.
- R11: `byteOffset` equals (`mappedAddr` × 4 + `plane`) modulo 2^18: `mappedAddr` in bits 17:2 and `plane` in bits 1:0.
- R12: The linear address is (`startAddr` + `charOffset`) modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| isRender | input | 1 | 1 = display refresh fetch, 0 = processor access |
| dwordMode | input | 1 | Doubleword addressing (highest priority) |
| byteMode | input | 1 | 1 = byte addressing, 0 = word addressing |
| wrapSel | input | 1 | Word-mode wrap source: 0 = bit 13, 1 = bit 15 |
| keepBit13 | input | 1 | 0 = put rowScan[0] on address bit 13 |
| keepBit14 | input | 1 | 0 = put rowScan[1] on address bit 14 |
| startAddr | input | 16 | Frame start address |
| charOffset | input | 16 | Running character offset |
| rowScan | input | 5 | Row scan counter |
| plane | input | 2 | Plane index |
| outValid | output | 1 | Result strobe, one clock after `inValid` |
| mappedAddr | output | 16 | Mapped character address |
| byteOffset | output | 18 | Plane-interleaved byte offset into video memory |

## Verification
The decoded mode state selects one bit-placement path. If that state is wrong, the fault shows one clock after the request as a `mappedAddr` whose low bits or bank bits disagree with an independent model:

- A wrong priority between doubleword and word mode shows up only when both selects are set at once.
- A wrong wrap source shows up only when linear bits 13 and 15 differ.
- A late substitution shows up only when the rotation moves a set bit into position 13 or 14.

The vectors are chosen so that each of these cases separates a correct path from a wrong one. A full sweep of the 64 mode combinations then confirms that the byte offset tracks the mapped address.

// File: rtl/crtc_map_pkg.sv
package crtc_map_pkg;

  // Strobes passed from the mode decoder to the address datapath.
  typedef struct packed {
    logic load;      // capture a new result this cycle
    logic rotDword;  // rotate left by two
    logic rotWord;   // rotate left by one
    logic wrapHigh;  // word-mode wrap source is the top bit
    logic sub13;     // put row scan bit 0 on the low bank bit
    logic sub14;     // put row scan bit 1 on the high bank bit
  } mapCtl_t;

endpackage

// File: rtl/crtc_map_ctrl.sv
module crtc_map_ctrl
  import crtc_map_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    isRender,
  input  logic    dwordMode,
  input  logic    byteMode,
  input  logic    wrapSel,
  input  logic    keepBit13,
  input  logic    keepBit14,
  output mapCtl_t ctl,
  output logic    outValid
);

  // Mode decode. Doubleword wins over word; processor accesses get no remap.
  always_comb begin
    ctl          = '0;
    ctl.load     = inValid;
    ctl.rotDword = isRender & dwordMode;
    ctl.rotWord  = isRender & ~dwordMode & ~byteMode;
    ctl.wrapHigh = wrapSel;
    ctl.sub13    = isRender & ~keepBit13;
    ctl.sub14    = isRender & ~keepBit14;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/crtc_map_dp.sv
module crtc_map_dp
  import crtc_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ROW_W   = 5,
  parameter int PLANE_W = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mapCtl_t                     ctl,
  input  logic [ADDR_W-1:0]           startAddr,
  input  logic [ADDR_W-1:0]           charOffset,
  input  logic [ROW_W-1:0]            rowScan,
  input  logic [PLANE_W-1:0]          plane,
  output logic [ADDR_W-1:0]           mappedAddr,
  output logic [ADDR_W+PLANE_W-1:0]   byteOffset
);

  localparam int OFF_W    = ADDR_W + PLANE_W;
  localparam int BANK_LSB = 13;             // first bit taking a row scan bit
  localparam int BANKS    = 2;              // number of substituted bits
  localparam int DW_SRC   = 12;             // lowest bit wrapped in doubleword mode
  localparam int WRAP_LO  = 13;             // word-mode wrap source, wrap clear
  localparam int WRAP_HI  = ADDR_W - 1;     // word-mode wrap source, wrap set

  logic [ADDR_W-1:0] linAddr;
  logic [ADDR_W-1:0] rotAddr;
  logic [ADDR_W-1:0] subAddr;
  logic [BANKS-1:0]  subEn;
  logic              wrapBit;

  assign linAddr = startAddr + charOffset;
  assign wrapBit = ctl.wrapHigh ? linAddr[WRAP_HI] : linAddr[WRAP_LO];
  assign subEn   = {ctl.sub14, ctl.sub13};

  // Stage 1: rotate by access width.
  always_comb begin
    if (ctl.rotDword)
      rotAddr = {linAddr[ADDR_W-3:0], linAddr[DW_SRC+1:DW_SRC]};
    else if (ctl.rotWord)
      rotAddr = {linAddr[ADDR_W-2:0], wrapBit};
    else
      rotAddr = linAddr;
  end

  // Stage 2: place row scan bits on the bank bits.
  always_comb begin
    subAddr = rotAddr;
    for (int i = 0; i < BANKS; i++) begin
      if (subEn[i]) subAddr[BANK_LSB+i] = rowScan[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mappedAddr <= '0;
      byteOffset <= '0;
    end else if (ctl.load) begin
      mappedAddr <= subAddr;
      byteOffset <= OFF_W'({subAddr, plane});
    end
  end

endmodule

// File: rtl/crtc_addr_map.sv
module crtc_addr_map
  import crtc_map_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ROW_W   = 5,
  parameter int PLANE_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic                      isRender,
  input  logic                      dwordMode,
  input  logic                      byteMode,
  input  logic                      wrapSel,
  input  logic                      keepBit13,
  input  logic                      keepBit14,
  input  logic [ADDR_W-1:0]         startAddr,
  input  logic [ADDR_W-1:0]         charOffset,
  input  logic [ROW_W-1:0]          rowScan,
  input  logic [PLANE_W-1:0]        plane,
  output logic                      outValid,
  output logic [ADDR_W-1:0]         mappedAddr,
  output logic [ADDR_W+PLANE_W-1:0] byteOffset
);

  mapCtl_t ctl;

  crtc_map_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .isRender  (isRender),
    .dwordMode (dwordMode),
    .byteMode  (byteMode),
    .wrapSel   (wrapSel),
    .keepBit13 (keepBit13),
    .keepBit14 (keepBit14),
    .ctl       (ctl),
    .outValid  (outValid)
  );

  crtc_map_dp #(
    .ADDR_W  (ADDR_W),
    .ROW_W   (ROW_W),
    .PLANE_W (PLANE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .startAddr  (startAddr),
    .charOffset (charOffset),
    .rowScan    (rowScan),
    .plane      (plane),
    .mappedAddr (mappedAddr),
    .byteOffset (byteOffset)
  );

endmodule

// File: rtl/crtc_map_chk.sv
module crtc_map_chk #(
  parameter int ADDR_W  = 16,
  parameter int ROW_W   = 5,
  parameter int PLANE_W = 2
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      inValid,
  input logic                      isRender,
  input logic                      dwordMode,
  input logic                      byteMode,
  input logic                      wrapSel,
  input logic                      keepBit13,
  input logic                      keepBit14,
  input logic [ADDR_W-1:0]         startAddr,
  input logic [ADDR_W-1:0]         charOffset,
  input logic [ROW_W-1:0]          rowScan,
  input logic [PLANE_W-1:0]        plane,
  input logic                      outValid,
  input logic [ADDR_W-1:0]         mappedAddr,
  input logic [ADDR_W+PLANE_W-1:0] byteOffset
);

  logic [ADDR_W-1:0] linSum;
  assign linSum = startAddr + charOffset;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);                                           // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);                                         // R1
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(mappedAddr) && $stable(byteOffset)));      // R2
  AST_CPU_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isRender) |=> (mappedAddr == $past(linSum)));       // R4
  AST_BYTE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isRender && byteMode && !dwordMode && keepBit13 && keepBit14)
      |=> (mappedAddr == $past(linSum)));                            // R5
  AST_BANK_LO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isRender && !keepBit13) |=> (mappedAddr[13] == $past(rowScan[0]))); // R9
  AST_BANK_HI: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isRender && !keepBit14) |=> (mappedAddr[14] == $past(rowScan[1]))); // R10
  AST_PLANE_POS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (byteOffset[PLANE_W-1:0] == $past(plane)));          // R11
  AST_OFFSET_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (byteOffset[ADDR_W+PLANE_W-1:PLANE_W] == mappedAddr)); // R11

endmodule

bind crtc_addr_map crtc_map_chk #(
  .ADDR_W  (ADDR_W),
  .ROW_W   (ROW_W),
  .PLANE_W (PLANE_W)
) u_chk (.*);

// File: tb/sim_crtc_addr_map.sv
module sim_crtc_addr_map;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid, isRender, dwordMode, byteMode, wrapSel, keepBit13, keepBit14;
  logic [15:0] startAddr, charOffset;
  logic [4:0]  rowScan;
  logic [1:0]  plane;
  logic        outValid;
  logic [15:0] mappedAddr;
  logic [17:0] byteOffset;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  crtc_addr_map u0 (.*);

  typedef struct packed {
    logic        rend, dw, bm, ws, k13, k14;
    logic [15:0] st, of;
    logic [4:0]  row;
    logic [1:0]  pl;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,16'h1234,16'h0100,5'd3,2'd1,16'h1334}, // R4 cpu
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,16'hABCD,16'h0000,5'd0,2'd2,16'hABCD}, // R5 byte
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,16'h2000,16'h0001,5'd0,2'd3,16'h4003}, // R6 word
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,16'h8000,16'h0000,5'd0,2'd0,16'h0001}, // R7 wrap hi
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,16'h8000,16'h0000,5'd0,2'd1,16'h0000}, // R6 wrap lo
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,16'h3000,16'h0001,5'd0,2'd2,16'hC007}, // R8 dword
    '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,16'h1200,16'h0034,5'd0,2'd3,16'h48D1}, // R8 priority
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,16'h0000,16'h0000,5'd1,2'd0,16'h2000}, // R9
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'hFFFF,16'h0000,5'd2,2'd1,16'hDFFF}, // R9 R10
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,16'h0000,16'h0000,5'd3,2'd2,16'h4000}, // R10
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'h1000,16'h0000,5'd0,2'd3,16'h0000}, // R9 order
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,16'hFFFF,16'h0002,5'd0,2'd0,16'h0001}, // R12
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0000,5'd3,2'd1,16'h0000}  // R4 cpu subst
  };

  function automatic string vecTag(int i);
    case (i)
      0, 12:   return "R4";
      1:       return "R5";
      2, 4:    return "R6";
      3:       return "R7";
      5, 6:    return "R8";
      7, 10:   return "R9";
      8:       return "R9 R10";
      9:       return "R10";
      default: return "R12";
    endcase
  endfunction

  // Independent arithmetic model of the mapping.
  function automatic logic [15:0] refMap(logic rend, logic dw, logic bm, logic ws,
                                         logic k13, logic k14,
                                         logic [15:0] a, logic [4:0] row);
    int unsigned v;
    int unsigned ai;
    ai = int'(a);
    v  = ai;
    if (rend) begin
      if (dw)       v = (ai * 4) % 65536 + (ai / 4096) % 4;
      else if (!bm) v = (ai * 2) % 65536 + (ws ? (ai / 32768) : (ai / 8192) % 2);
      if (!k13) v = (v & ~32'h2000) | ((int'(row) % 2) * 8192);
      if (!k14) v = (v & ~32'h4000) | (((int'(row) / 2) % 2) * 16384);
    end
    return v[15:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic rend, logic dw, logic bm, logic ws, logic k13, logic k14,
                       logic [15:0] st, logic [15:0] of, logic [4:0] row, logic [1:0] pl);
    inValid = 1'b1; isRender = rend; dwordMode = dw; byteMode = bm; wrapSel = ws;
    keepBit13 = k13; keepBit14 = k14; startAddr = st; charOffset = of;
    rowScan = row; plane = pl;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 5'd3, 2'd3);
    repeat (3) @(negedge clk);
    check("R3 outValid", 32'(outValid), 32'd0);
    check("R3 mappedAddr", 32'(mappedAddr), 32'd0);
    check("R3 byteOffset", 32'(byteOffset), 32'd0);
    rstN = 1'b1; inValid = 1'b0;
    @(negedge clk);

    // Vector table.
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].rend, VECS[i].dw, VECS[i].bm, VECS[i].ws, VECS[i].k13, VECS[i].k14,
            VECS[i].st, VECS[i].of, VECS[i].row, VECS[i].pl);
      @(negedge clk);
      check({vecTag(i), " R1 outValid"}, 32'(outValid), 32'd1);
      check({vecTag(i), " mappedAddr"}, 32'(mappedAddr), 32'(VECS[i].exp));
      check({vecTag(i), " R11 byteOffset"}, 32'(byteOffset), 32'({VECS[i].exp, VECS[i].pl}));
    end

    // Hold with no strobe: R1, R2.
    inValid = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h5555, 16'h1111, 5'd2, 2'd2);
    inValid = 1'b0;
    @(negedge clk);
    check("R1 outValid low", 32'(outValid), 32'd0);
    @(negedge clk);
    check("R2 mappedAddr held", 32'(mappedAddr), 32'h0000);
    check("R2 byteOffset held", 32'(byteOffset), 32'h00001);

    // Full mode sweep against the model.
    for (int m = 0; m < 64; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [15:0] st, of, e;
        logic [4:0]  row;
        logic [1:0]  pl;
        st  = 16'hA5C3 ^ 16'(k * 16'h3711);
        of  = 16'(m * 16'h0123 + k);
        row = 5'(m + k);
        pl  = 2'(k + m);
        drive(m[5], m[4], m[3], m[2], m[1], m[0], st, of, row, pl);
        e = refMap(m[5], m[4], m[3], m[2], m[1], m[0], 16'(st + of), row);
        @(negedge clk);
        check("R6 R7 R8 R9 R10 sweep mappedAddr", 32'(mappedAddr), 32'(e));
        check("R11 sweep byteOffset", 32'(byteOffset), 32'({e, pl}));
      end
    end

    // Reset after activity clears everything: R3.
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 5'd0, 2'd3);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R3 reset outValid", 32'(outValid), 32'd0);
    check("R3 reset mappedAddr", 32'(mappedAddr), 32'd0);
    check("R3 reset byteOffset", 32'(byteOffset), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule